// File: doc/BRIEF.md
# Cycle-Stealing Block Transfer Engine

This engine is a bus master. It moves a block of words between one I/O device location and a run of memory words. Software programs four things before it starts: the transfer direction, the device address, the first memory address and the number of words.

After a start command, the engine takes the shared bus for exactly one word at a time. For each word it requests the bus and waits for the grant. It then issues two back-to-back transactions: a read from the source and a write of that same word to the destination. In the cycle after the write it lets the bus go. The processor is never interrupted while this happens; it only loses the bus cycles the engine holds.

After each word the memory address steps up by one and the remaining count steps down by one. When the count reaches zero, a completion flag is set and drives the interrupt line. Software clears the flag by writing a one to it.

Top module: `cs_dma_ctrl`

## Requirements
- R1: Register select 1 holds the device address, select 2 the memory address and select 3 the word count; each reads back what was written while idle. Select 0 is control/status. On write, bit 0 is start, bit 1 is direction (0 = device to memory, 1 = memory to device) and bit 2 is done-clear. On read, bit 0 is busy, bit 1 is the latched direction and bit 2 is done.
- R2: A start with a nonzero count raises bus_req_o. bus_req_o stays high until bus_grant_i is seen. No transaction (bus_valid_o) is issued without both request and grant.
- R3: Each word takes two transactions in consecutive cycles. The first is a read (bus_we_o=0) from the source. The second is a write (bus_we_o=1) to the destination, carrying the data just read. bus_io_o=1 marks device space and 0 marks memory space. Direction 0 reads the device and writes memory; direction 1 does the reverse.
- R4: bus_req_o falls in the cycle after each word's write, so a block of N words produces exactly N rising edges of bus_req_o.
- R5: The memory address advances by one per word and the count falls by one per word; the device address is unchanged. After a block of N words from start address A, the readback shows A+N and a count of 0.
- R6: When the last word completes, busy clears and done/irq_o rise together.
- R7: Writing control with bit 2 set clears done and irq_o. A control write with bit 2 clear and no start leaves done set.
- R8: While busy, a start write and writes to the address and count registers are ignored. The running block finishes with its original parameters.
- R9: A start with a count of 0 sets done in the next cycle and never raises bus_req_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_sel_i | input | 2 | Register select |
| cfg_wdata_i | input | AW | Register write data |
| cfg_rdata_o | output | AW | Register read data (combinational) |
| bus_req_o | output | 1 | Bus request |
| bus_grant_i | input | 1 | Bus grant from the arbiter |
| bus_valid_o | output | 1 | Transaction valid this cycle |
| bus_we_o | output | 1 | 1 = write, 0 = read |
| bus_io_o | output | 1 | 1 = device space, 0 = memory space |
| bus_addr_o | output | AW | Transaction address |
| bus_wdata_o | output | DW | Write data |
| bus_rdata_i | input | DW | Read data, valid in the read cycle |
| irq_o | output | 1 | Completion interrupt (done flag) |

## Verification
The bench sweeps both directions, block lengths of 0, 1, 2, 3 and 5 words, and arbiter grant delays of 0 to 2 cycles. Each block goes to its own memory region.

- Zero-length blocks separate the immediate-done path from the bus path.
- Single-word and multi-word blocks show whether the address steps and whether the bus is released between words. The latter appears in the count of request edges.
- Varying the grant delay shows whether the engine holds its request and waits, rather than transferring early.
- A device source that returns an increasing value, and memory pre-filled with an address-derived pattern, expose any lost, repeated or reordered word.

A separate run restarts and rewrites registers during a block, to confirm those writes leave the transfer untouched.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_SRC,
    ST_DST,
    ST_REL
  } dma_state_e;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_DEV  = 2'd1;
  localparam logic [1:0] SEL_MEM  = 2'd2;
  localparam logic [1:0] SEL_CNT  = 2'd3;

  localparam int CTRL_START = 0;
  localparam int CTRL_DIR   = 1;
  localparam int CTRL_DONE  = 2;
endpackage

// File: rtl/dma_regs.sv
module dma_regs
  import dma_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic [1:0]    cfg_sel_i,
  input  logic [AW-1:0] cfg_wdata_i,
  input  logic          busy_i,
  input  logic          word_i,
  input  logic          fin_i,
  output logic          go_o,
  output logic          dir_o,
  output logic          done_o,
  output logic [AW-1:0] dev_addr_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [AW-1:0] cnt_o,
  output logic [AW-1:0] cfg_rdata_o
);
  logic          dir_q, done_q;
  logic [AW-1:0] dev_q, mem_q, cnt_q;
  logic          wr_ctrl, start_acc, cnt_zero;

  assign wr_ctrl   = cfg_we_i && (cfg_sel_i == SEL_CTRL);
  assign start_acc = wr_ctrl && cfg_wdata_i[CTRL_START] && !busy_i;
  assign cnt_zero  = (cnt_q == '0);
  assign go_o      = start_acc && !cnt_zero;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (start_acc) dir_q <= cfg_wdata_i[CTRL_DIR];
      // set outranks clear
      if (fin_i || (start_acc && cnt_zero)) done_q <= 1'b1;
      else if (start_acc)                   done_q <= 1'b0;
      else if (wr_ctrl && cfg_wdata_i[CTRL_DONE]) done_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dev_q <= '0;
      mem_q <= '0;
      cnt_q <= '0;
    end else if (word_i) begin
      mem_q <= mem_q + 1'b1;
      cnt_q <= cnt_q - 1'b1;
    end else if (cfg_we_i && !busy_i) begin
      case (cfg_sel_i)
        SEL_DEV: dev_q <= cfg_wdata_i;
        SEL_MEM: mem_q <= cfg_wdata_i;
        SEL_CNT: cnt_q <= cfg_wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    cfg_rdata_o = '0;
    case (cfg_sel_i)
      SEL_CTRL: begin
        cfg_rdata_o[CTRL_START] = busy_i;
        cfg_rdata_o[CTRL_DIR]   = dir_q;
        cfg_rdata_o[CTRL_DONE]  = done_q;
      end
      SEL_DEV: cfg_rdata_o = dev_q;
      SEL_MEM: cfg_rdata_o = mem_q;
      default: cfg_rdata_o = cnt_q;
    endcase
  end

  assign dir_o      = dir_q;
  assign done_o     = done_q;
  assign dev_addr_o = dev_q;
  assign mem_addr_o = mem_q;
  assign cnt_o      = cnt_q;
endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import dma_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       go_i,
  input  logic       grant_i,
  input  logic       last_i,
  output dma_state_e state_o,
  output logic       busy_o,
  output logic       req_o,
  output logic       word_o,
  output logic       fin_o
);
  dma_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (go_i) state_d = ST_REQ;
      ST_REQ:  if (grant_i) state_d = ST_SRC;
      ST_SRC:  state_d = ST_DST;
      ST_DST:  state_d = ST_REL;
      ST_REL:  state_d = last_i ? ST_IDLE : ST_REQ;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
  assign busy_o  = (state_q != ST_IDLE);
  assign req_o   = (state_q == ST_REQ) || (state_q == ST_SRC) || (state_q == ST_DST);
  assign word_o  = (state_q == ST_DST);
  // count already decremented when in ST_REL
  assign fin_o   = (state_q == ST_REL) && last_i;
endmodule

// File: rtl/dma_xfer_path.sv
module dma_xfer_path
  import dma_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  dma_state_e    state_i,
  input  logic          dir_i,
  input  logic [AW-1:0] dev_addr_i,
  input  logic [AW-1:0] mem_addr_i,
  input  logic [DW-1:0] rdata_i,
  output logic          valid_o,
  output logic          we_o,
  output logic          io_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o
);
  logic          src_io;
  logic [DW-1:0] data_q;

  assign src_io = ~dir_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                data_q <= '0;
    else if (state_i == ST_SRC) data_q <= rdata_i;
  end

  always_comb begin
    valid_o = 1'b0;
    we_o    = 1'b0;
    io_o    = 1'b0;
    addr_o  = '0;
    case (state_i)
      ST_SRC: begin
        valid_o = 1'b1;
        io_o    = src_io;
        addr_o  = src_io ? dev_addr_i : mem_addr_i;
      end
      ST_DST: begin
        valid_o = 1'b1;
        we_o    = 1'b1;
        io_o    = ~src_io;
        addr_o  = src_io ? mem_addr_i : dev_addr_i;
      end
      default: ;
    endcase
  end

  assign wdata_o = data_q;
endmodule

// File: rtl/cs_dma_ctrl.sv
module cs_dma_ctrl
  import dma_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic [1:0]    cfg_sel_i,
  input  logic [AW-1:0] cfg_wdata_i,
  output logic [AW-1:0] cfg_rdata_o,
  output logic          bus_req_o,
  input  logic          bus_grant_i,
  output logic          bus_valid_o,
  output logic          bus_we_o,
  output logic          bus_io_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [DW-1:0] bus_wdata_o,
  input  logic [DW-1:0] bus_rdata_i,
  output logic          irq_o
);
  dma_state_e    state_w;
  logic          go_w, dir_w, done_w, busy_w, word_w, fin_w;
  logic [AW-1:0] dev_w, mem_w, cnt_w;

  dma_regs #(.AW(AW)) i_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cfg_we_i   (cfg_we_i),
    .cfg_sel_i  (cfg_sel_i),
    .cfg_wdata_i(cfg_wdata_i),
    .busy_i     (busy_w),
    .word_i     (word_w),
    .fin_i      (fin_w),
    .go_o       (go_w),
    .dir_o      (dir_w),
    .done_o     (done_w),
    .dev_addr_o (dev_w),
    .mem_addr_o (mem_w),
    .cnt_o      (cnt_w),
    .cfg_rdata_o(cfg_rdata_o)
  );

  dma_seq i_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .go_i   (go_w),
    .grant_i(bus_grant_i),
    .last_i (cnt_w == '0),
    .state_o(state_w),
    .busy_o (busy_w),
    .req_o  (bus_req_o),
    .word_o (word_w),
    .fin_o  (fin_w)
  );

  dma_xfer_path #(.AW(AW), .DW(DW)) i_path (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .state_i   (state_w),
    .dir_i     (dir_w),
    .dev_addr_i(dev_w),
    .mem_addr_i(mem_w),
    .rdata_i   (bus_rdata_i),
    .valid_o   (bus_valid_o),
    .we_o      (bus_we_o),
    .io_o      (bus_io_o),
    .addr_o    (bus_addr_o),
    .wdata_o   (bus_wdata_o)
  );

  assign irq_o = done_w;
endmodule

// File: rtl/dma_chk.sv
module dma_chk #(
  parameter int AW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cfg_we_i,
  input logic [1:0]    cfg_sel_i,
  input logic          start_bit_i,
  input logic          busy_i,
  input logic [AW-1:0] cnt_i,
  input logic          bus_req_i,
  input logic          bus_grant_i,
  input logic          bus_valid_i,
  input logic          bus_we_i,
  input logic          bus_io_i,
  input logic          irq_i
);
  // R2
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_i && !bus_grant_i |=> bus_req_i);

  // R2
  valid_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_valid_i |-> bus_req_i && bus_grant_i);

  // R3
  word_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_valid_i && !bus_we_i |=> bus_valid_i && bus_we_i && (bus_io_i != $past(bus_io_i)));

  // R4
  release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_valid_i && bus_we_i |=> !bus_req_i);

  // R6
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_i) |-> !busy_i);

  // R9
  zero_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i && cfg_sel_i == 2'd0 && start_bit_i && !busy_i && cnt_i == '0
    |=> irq_i && !bus_req_i);
endmodule

bind cs_dma_ctrl dma_chk #(.AW(AW)) i_dma_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cfg_we_i   (cfg_we_i),
  .cfg_sel_i  (cfg_sel_i),
  .start_bit_i(cfg_wdata_i[0]),
  .busy_i     (busy_w),
  .cnt_i      (cnt_w),
  .bus_req_i  (bus_req_o),
  .bus_grant_i(bus_grant_i),
  .bus_valid_i(bus_valid_o),
  .bus_we_i   (bus_we_o),
  .bus_io_i   (bus_io_o),
  .irq_i      (irq_o)
);

// File: tb/test_cs_dma_ctrl.sv
`timescale 1ns/1ps
module test_cs_dma_ctrl;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam logic [15:0] DEV_BASE = 16'hA500;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_sel = 2'd0;
  logic [AW-1:0] cfg_wdata = '0;
  logic [AW-1:0] cfg_rdata;
  logic          bus_req, bus_grant, bus_valid, bus_we, bus_io, irq;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int gnt_delay = 0;
  logic          exp_dir = 1'b0;
  logic [AW-1:0] exp_dev = '0;

  // bench-side bus stub
  logic [15:0] mem [256];
  logic [15:0] dev_log [256];
  int          log_n, trans, req_rises, order_err, gcnt;
  logic [15:0] dev_rd;
  logic        prev_req, prev_valid, prev_we;

  always #10 clk = ~clk;

  cs_dma_ctrl #(.AW(AW), .DW(DW)) i_cs_dma_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel), .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata),
    .bus_req_o(bus_req), .bus_grant_i(bus_grant), .bus_valid_o(bus_valid),
    .bus_we_o(bus_we), .bus_io_o(bus_io), .bus_addr_o(bus_addr),
    .bus_wdata_o(bus_wdata), .bus_rdata_i(bus_rdata), .irq_o(irq)
  );

  function automatic logic [15:0] fill(input int a);
    return 16'(a * 16'h0101) ^ 16'h5A3C;
  endfunction

  assign bus_rdata = bus_io ? (DEV_BASE + dev_rd) : mem[bus_addr[7:0]];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) begin mem[i] <= fill(i); dev_log[i] <= '0; end
      log_n <= 0; trans <= 0; req_rises <= 0; order_err <= 0; gcnt <= 0;
      dev_rd <= '0; prev_req <= 1'b0; prev_valid <= 1'b0; prev_we <= 1'b0;
      bus_grant <= 1'b0;
    end else begin
      if (!bus_req) begin bus_grant <= 1'b0; gcnt <= 0; end
      else if (gcnt >= gnt_delay) bus_grant <= 1'b1;
      else gcnt <= gcnt + 1;
      prev_req <= bus_req;
      if (bus_req && !prev_req) req_rises <= req_rises + 1;
      if (bus_valid) begin
        trans <= trans + 1;
        if (bus_io && bus_addr != exp_dev) order_err <= order_err + 1;
        if (!bus_we) begin
          if (bus_io != !exp_dir) order_err <= order_err + 1;
          if (bus_io) dev_rd <= dev_rd + 1'b1;
        end else begin
          if (!prev_valid || prev_we || bus_io != exp_dir) order_err <= order_err + 1;
          if (bus_io) begin dev_log[log_n[7:0]] <= bus_wdata; log_n <= log_n + 1; end
          else mem[bus_addr[7:0]] <= bus_wdata;
        end
      end
      prev_valid <= bus_valid;
      prev_we    <= bus_we;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] sel, input logic [AW-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_read(input logic [1:0] sel, output logic [AW-1:0] d);
    cfg_sel = sel;
    #1 d = cfg_rdata;
  endtask

  task automatic wait_irq();
    for (int i = 0; i < 400; i++) begin
      if (irq) break;
      @(negedge clk);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
        finish_run();
      end
    end
  end

  initial begin
    logic [AW-1:0] rd;
    int t0, r0, d0, l0, bad;
    do_reset();

    // reset state
    chk(irq == 1'b0, "R6 irq after reset", irq, 0);
    chk(bus_req == 1'b0, "R2 req after reset", bus_req, 0);
    cfg_read(2'd0, rd); chk(rd == '0, "R1 status after reset", rd, 0);

    // R1 readback of programmed registers
    cfg_write(2'd1, 16'h1234); cfg_write(2'd2, 16'h00F0); cfg_write(2'd3, 16'h0007);
    cfg_read(2'd1, rd); chk(rd == 16'h1234, "R1 device addr", rd, 16'h1234);
    cfg_read(2'd2, rd); chk(rd == 16'h00F0, "R1 memory addr", rd, 16'h00F0);
    cfg_read(2'd3, rd); chk(rd == 16'h0007, "R1 count", rd, 7);

    // sweep: direction x length x grant delay
    for (int d = 0; d < 2; d++) begin
      for (int ni = 0; ni < 5; ni++) begin
        for (int g = 0; g < 3; g++) begin
          int n, id, st;
          n  = (ni == 4) ? 5 : ni;
          id = d * 15 + ni * 3 + g;
          st = id * 8;
          gnt_delay = g;
          exp_dir = d[0];
          exp_dev = 16'(16'h0030 + id);
          cfg_write(2'd1, exp_dev);
          cfg_write(2'd2, 16'(st));
          cfg_write(2'd3, 16'(n));
          t0 = trans; r0 = req_rises; d0 = int'(dev_rd); l0 = log_n;
          cfg_write(2'd0, 16'({d[0], 1'b1}));
          if (n == 0) chk(irq == 1'b1, "R9 zero count done next cycle", irq, 1);
          else begin
            wait_irq();
            chk(irq == 1'b1, "R6 irq on completion", irq, 1);
          end
          cfg_read(2'd0, rd);
          chk(rd[2:0] == {1'b1, d[0], 1'b0}, "R6 status done, not busy", rd, {1'b1, d[0], 1'b0});
          cfg_read(2'd2, rd); chk(rd == 16'(st + n), "R5 final memory addr", rd, st + n);
          cfg_read(2'd3, rd); chk(rd == '0, "R5 final count", rd, 0);
          cfg_read(2'd1, rd); chk(rd == exp_dev, "R5 device addr unchanged", rd, exp_dev);
          chk(trans - t0 == 2 * n, "R3 two transactions per word", trans - t0, 2 * n);
          chk(req_rises - r0 == n, "R4 bus released per word (R9 none at zero)", req_rises - r0, n);
          bad = 0;
          if (d == 0) begin
            for (int k = 0; k < n; k++)
              if (mem[st + k] != 16'(DEV_BASE + d0 + k)) bad++;
            if (mem[st + n] != fill(st + n)) bad++;
          end else begin
            if (log_n - l0 != n) bad++;
            for (int k = 0; k < n; k++)
              if (dev_log[l0 + k] != fill(st + k)) bad++;
          end
          chk(bad == 0, "R3 data moved source to destination", bad, 0);
          cfg_write(2'd0, 16'h0004);
          chk(irq == 1'b0, "R7 done cleared by write-one", irq, 0);
        end
      end
    end
    chk(order_err == 0, "R3 transaction order/space/address", order_err, 0);

    // R7 control write without clear bit keeps done
    do_reset();
    cfg_write(2'd3, 16'h0000);
    cfg_write(2'd0, 16'h0001);
    cfg_write(2'd0, 16'h0000);
    chk(irq == 1'b1, "R7 write without clear bit keeps done", irq, 1);
    cfg_write(2'd0, 16'h0004);

    // R8 writes while busy are ignored
    gnt_delay = 1;
    exp_dir = 1'b0;
    exp_dev = 16'h0077;
    cfg_write(2'd1, 16'h0077);
    cfg_write(2'd2, 16'h0010);
    cfg_write(2'd3, 16'h0004);
    t0 = trans; r0 = req_rises;
    cfg_write(2'd0, 16'h0001);
    cfg_write(2'd0, 16'h0003);
    cfg_write(2'd3, 16'h0001);
    cfg_write(2'd2, 16'h0080);
    cfg_write(2'd1, 16'h0099);
    wait_irq();
    chk(irq == 1'b1, "R8 block completes", irq, 1);
    cfg_read(2'd2, rd); chk(rd == 16'h0014, "R8 memory addr unaffected", rd, 16'h0014);
    cfg_read(2'd1, rd); chk(rd == 16'h0077, "R8 device addr unaffected", rd, 16'h0077);
    cfg_read(2'd0, rd); chk(rd[1] == 1'b0, "R8 direction not relatched", rd[1], 0);
    chk(trans - t0 == 8, "R8 original word count moved", trans - t0, 8);
    chk(req_rises - r0 == 4, "R8 no extra block started", req_rises - r0, 4);
    chk(order_err == 0, "R3 order during busy writes", order_err, 0);

    finish_run();
  end
endmodule